// File: doc/BRIEF.md
# Line Eviction Writeback Sequencer

This block moves one cache line out of its array and toward the directory and memory. When a replacement is accepted, the line's data is copied into a single transaction buffer. A victim message is sent, and a one-cycle pulse tells the array to invalidate its copy. Lines that are modified or owned leave as dirty victims. Exclusive or shared lines leave as clean victims. The buffer stays occupied until memory acknowledges the writeback.

While the eviction is pending, coherence probes for the line may still arrive. These probes are answered from the buffer. An invalidating probe moves the sequencer into a cancelled phase. In that phase the line is treated as absent, but the sequencer still waits for the memory acknowledgement before it frees the buffer. Victim write announcements from the caches above are told to retry while the sequencer is cancelled. Which line to evict is decided elsewhere.

Top module: `evict_seq`

## Requirements
- R1: An accepted replacement of a line whose state code is M (2'b11) or O (2'b10) sends, on the next cycle, `vic_valid`=1 with `vic_dirty`=1 and the line's address and data. The same acceptance pulses `array_inv` combinationally. `phase` then becomes dirty-wait (2'b01), and the buffer's dirty flag is set to 1.
- R2: An accepted replacement of a line whose state code is E (2'b01) or S (2'b00) sends, on the next cycle, `vic_valid`=1 with `vic_dirty`=0 and the line's address and data. It pulses `array_inv` and moves `phase` to clean-wait (2'b10). The buffer's dirty flag is set to 0.
- R3: A `wb_ack` seen in dirty-wait, clean-wait or cancelled (2'b11) frees the buffer, and `phase` returns to idle (2'b00) on the next cycle. This holds even when a probe arrives in the same cycle. A `wb_ack` in idle has no effect.
- R4: In dirty-wait, an invalidating probe (`prb_kind` 2'b00 without data, 2'b01 with data) moves `phase` to cancelled. With data requested, the reply carries `prb_rsp_has_data`=1, the buffer data, `prb_rsp_dirty` equal to the buffer's dirty flag, and `prb_rsp_hit`=1. Without data, the reply is the not-present reply of R5.
- R5: In clean-wait, either invalidating probe gets a not-present reply and moves `phase` to cancelled. The not-present reply has no data, `prb_rsp_ntsl`=1, `prb_rsp_hit`=0 and `prb_rsp_dirty`=0.
- R6: In dirty-wait or clean-wait, a downgrade probe (`prb_kind` 2'b10 or 2'b11) gets a reply with the buffer data, the buffer's dirty flag and `prb_rsp_hit`=1, and `phase` does not change.
- R7: In cancelled or idle, invalidating probes get the not-present reply. Downgrade probes get the miss reply, in which data, dirty, hit and ntsl are all 0.
- R8: `repl_ready` is high only when `phase` is idle and `repl_line_busy` is low. A `repl_valid` while `repl_ready` is low sends nothing, leaves `phase` unchanged and does not pulse `array_inv`.
- R9: `vic_retry` follows `vic_announce` combinationally while `phase` is cancelled, and stays low in every other phase.
- R10: Every probe produces exactly one reply, with `prb_rsp_valid` high for one cycle, on the cycle after the probe. The reply is decided from the phase held before that edge. All reply fields, and all victim fields, are zero whenever their valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| repl_valid | input | 1 | Replacement trigger |
| repl_ready | output | 1 | Replacement can be accepted this cycle |
| repl_line_busy | input | 1 | Target line is in a writeback-acceptance transient; defer |
| repl_state | input | 2 | Line state: 11 M, 10 O, 01 E, 00 S |
| repl_addr | input | ADDR_W | Line address |
| repl_data | input | DATA_W | Line data |
| array_inv | output | 1 | Invalidate the array entry (same cycle as acceptance) |
| prb_valid | input | 1 | Probe present |
| prb_kind | input | 2 | 00 invalidate, 01 invalidate with data, 1x downgrade |
| wb_ack | input | 1 | Memory writeback acknowledgement |
| vic_announce | input | 1 | Victim write announcement from above |
| vic_retry | output | 1 | Announcement must be retried |
| vic_valid | output | 1 | Victim message to directory |
| vic_dirty | output | 1 | 1 dirty victim, 0 clean victim |
| vic_addr | output | ADDR_W | Victim address |
| vic_data | output | DATA_W | Victim data |
| prb_rsp_valid | output | 1 | Probe reply |
| prb_rsp_has_data | output | 1 | Reply carries data |
| prb_rsp_dirty | output | 1 | Reply data is dirty |
| prb_rsp_hit | output | 1 | Reply hit flag |
| prb_rsp_ntsl | output | 1 | Reply not-present flag |
| prb_rsp_data | output | DATA_W | Reply data |
| phase | output | 2 | 00 idle, 01 dirty-wait, 10 clean-wait, 11 cancelled |

## Verification
The bench targets the races around a pending writeback: probes in each phase, and a probe arriving in the same cycle as the acknowledgement or as a new replacement.

- A design that let a probe's phase change override the acknowledgement would stay cancelled with no acknowledgement left to come. The sequencer would then hang.
- A design that answered a downgrade from the array rather than the buffer, or that cancelled on a downgrade, would return wrong data or lose the line's ownership.
- A deferred or blocked replacement is checked so that a sequencer that accepts it while busy shows a second victim or a spurious invalidate pulse.
- A sequencer that retries announcements outside the cancelled phase is caught at `vic_retry`.

// File: rtl/evict_seq.sv
module evict_seq #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              repl_valid,
  output logic              repl_ready,
  input  logic              repl_line_busy,
  input  logic [1:0]        repl_state,
  input  logic [ADDR_W-1:0] repl_addr,
  input  logic [DATA_W-1:0] repl_data,
  output logic              array_inv,
  input  logic              prb_valid,
  input  logic [1:0]        prb_kind,
  input  logic              wb_ack,
  input  logic              vic_announce,
  output logic              vic_retry,
  output logic              vic_valid,
  output logic              vic_dirty,
  output logic [ADDR_W-1:0] vic_addr,
  output logic [DATA_W-1:0] vic_data,
  output logic              prb_rsp_valid,
  output logic              prb_rsp_has_data,
  output logic              prb_rsp_dirty,
  output logic              prb_rsp_hit,
  output logic              prb_rsp_ntsl,
  output logic [DATA_W-1:0] prb_rsp_data,
  output logic [1:0]        phase
);
  localparam logic [1:0] PH_IDLE = 2'b00;
  localparam logic [1:0] PH_DIRTY = 2'b01;
  localparam logic [1:0] PH_CLEAN = 2'b10;
  localparam logic [1:0] PH_CANCEL = 2'b11;

  logic [DATA_W-1:0] buf_data;
  logic              buf_dirty;
  logic              waiting;
  logic              inv_probe;
  logic [1:0]        phase_nx;

  assign repl_ready = (phase == PH_IDLE) && !repl_line_busy;
  assign array_inv  = repl_valid && repl_ready;
  assign vic_retry  = vic_announce && (phase == PH_CANCEL);
  assign waiting    = (phase == PH_DIRTY) || (phase == PH_CLEAN);
  assign inv_probe  = prb_valid && !prb_kind[1];

  always_comb begin
    phase_nx = phase;
    if (array_inv) phase_nx = repl_state[1] ? PH_DIRTY : PH_CLEAN;
    if (inv_probe && waiting) phase_nx = PH_CANCEL;
    if (wb_ack && phase != PH_IDLE) phase_nx = PH_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase            <= PH_IDLE;
      buf_data         <= '0;
      buf_dirty        <= 1'b0;
      vic_valid        <= 1'b0;
      vic_dirty        <= 1'b0;
      vic_addr         <= '0;
      vic_data         <= '0;
      prb_rsp_valid    <= 1'b0;
      prb_rsp_has_data <= 1'b0;
      prb_rsp_dirty    <= 1'b0;
      prb_rsp_hit      <= 1'b0;
      prb_rsp_ntsl     <= 1'b0;
      prb_rsp_data     <= '0;
    end else begin
      phase            <= phase_nx;
      vic_valid        <= array_inv;
      vic_dirty        <= array_inv && repl_state[1];
      vic_addr         <= array_inv ? repl_addr : '0;
      vic_data         <= array_inv ? repl_data : '0;
      prb_rsp_valid    <= prb_valid;
      prb_rsp_has_data <= 1'b0;
      prb_rsp_dirty    <= 1'b0;
      prb_rsp_hit      <= 1'b0;
      prb_rsp_ntsl     <= 1'b0;
      prb_rsp_data     <= '0;
      if (array_inv) begin
        buf_data  <= repl_data;
        buf_dirty <= repl_state[1];
      end
      if (prb_valid) begin
        if (waiting && (prb_kind[1] || (phase == PH_DIRTY && prb_kind[0]))) begin
          prb_rsp_has_data <= 1'b1;
          prb_rsp_dirty    <= buf_dirty;
          prb_rsp_hit      <= 1'b1;
          prb_rsp_data     <= buf_data;
        end else if (!prb_kind[1]) begin
          prb_rsp_ntsl <= 1'b1;
        end
      end
    end
  end

  AST_ACCEPT_SENDS: assert property (@(posedge clk) disable iff (!rst_n)
    array_inv |=> vic_valid && phase != PH_IDLE); // R1
  AST_ACK_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_ack && phase != PH_IDLE) |=> phase == PH_IDLE); // R3
  AST_DATA_HAS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    prb_rsp_has_data |-> prb_rsp_hit && !prb_rsp_ntsl); // R6
  AST_DOWNGRADE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (prb_valid && prb_kind[1] && waiting && !wb_ack) |=> $stable(phase)); // R6
  AST_CANCEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CANCEL && !wb_ack) |=> phase == PH_CANCEL); // R7
  AST_ONE_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
    prb_valid |=> prb_rsp_valid); // R10
endmodule

// File: tb/evict_seq_tb.sv
module evict_seq_tb;
  localparam int AW = 16;
  localparam int DW = 32;

  logic clk = 0;
  logic rst_n = 0;
  logic repl_valid = 0, repl_line_busy = 0, prb_valid = 0, wb_ack = 0, vic_announce = 0;
  logic [1:0] repl_state = 0, prb_kind = 0;
  logic [AW-1:0] repl_addr = 0;
  logic [DW-1:0] repl_data = 0;
  logic repl_ready, array_inv, vic_retry, vic_valid, vic_dirty;
  logic [AW-1:0] vic_addr;
  logic [DW-1:0] vic_data, prb_rsp_data;
  logic prb_rsp_valid, prb_rsp_has_data, prb_rsp_dirty, prb_rsp_hit, prb_rsp_ntsl;
  logic [1:0] phase;

  int n_cmp = 0, n_bad = 0;

  // model state
  int m_phase = 0;
  logic [DW-1:0] m_buf = 0;
  logic m_bdirty = 0;
  logic e_vv = 0, e_vd = 0, e_pv = 0, e_pdat = 0, e_pdirty = 0, e_phit = 0, e_pntsl = 0;
  logic [AW-1:0] e_va = 0;
  logic [DW-1:0] e_vdat = 0, e_pdata = 0;
  string prb_req = "R10";

  always #2 clk = ~clk;

  evict_seq #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk, .rst_n, .repl_valid, .repl_ready, .repl_line_busy, .repl_state, .repl_addr,
    .repl_data, .array_inv, .prb_valid, .prb_kind, .wb_ack, .vic_announce, .vic_retry,
    .vic_valid, .vic_dirty, .vic_addr, .vic_data, .prb_rsp_valid, .prb_rsp_has_data,
    .prb_rsp_dirty, .prb_rsp_hit, .prb_rsp_ntsl, .prb_rsp_data, .phase);

  task automatic chk(string req, string what, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cmp_regs();
    chk("R3", "phase", phase, m_phase);
    chk(e_vd ? "R1" : "R2", "vic_valid", vic_valid, e_vv);
    chk(e_vd ? "R1" : "R2", "vic_dirty", vic_dirty, e_vd);
    chk("R1", "vic_addr", vic_addr, e_va);
    chk("R2", "vic_data", vic_data, e_vdat);
    chk("R10", "prb_rsp_valid", prb_rsp_valid, e_pv);
    chk(prb_req, "prb_rsp_has_data", prb_rsp_has_data, e_pdat);
    chk(prb_req, "prb_rsp_dirty", prb_rsp_dirty, e_pdirty);
    chk(prb_req, "prb_rsp_hit", prb_rsp_hit, e_phit);
    chk(prb_req, "prb_rsp_ntsl", prb_rsp_ntsl, e_pntsl);
    chk(prb_req, "prb_rsp_data", prb_rsp_data, e_pdata);
  endtask

  // one cycle: drive, check combinational, clock, update model, check registers
  task automatic cyc(logic rv, logic busy, logic [1:0] st, logic [AW-1:0] a, logic [DW-1:0] d,
                     logic pv, logic [1:0] pk, logic ack, logic ann);
    logic e_rdy;
    int np;
    @(negedge clk);
    repl_valid = rv; repl_line_busy = busy; repl_state = st; repl_addr = a; repl_data = d;
    prb_valid = pv; prb_kind = pk; wb_ack = ack; vic_announce = ann;
    #1;
    e_rdy = (m_phase == 0) && !busy;
    chk("R8", "repl_ready", repl_ready, e_rdy);
    chk("R8", "array_inv", array_inv, rv && e_rdy);
    chk("R9", "vic_retry", vic_retry, ann && m_phase == 3);
    @(posedge clk);
    np = m_phase;
    e_vv = 0; e_vd = 0; e_va = 0; e_vdat = 0;
    e_pv = pv; e_pdat = 0; e_pdirty = 0; e_phit = 0; e_pntsl = 0; e_pdata = 0;
    prb_req = "R10";
    if (pv) begin
      if ((m_phase == 1 || m_phase == 2) && pk[1]) begin
        e_pdat = 1; e_pdirty = m_bdirty; e_phit = 1; e_pdata = m_buf; prb_req = "R6";
      end else if (m_phase == 1 && pk == 2'b01) begin
        e_pdat = 1; e_pdirty = m_bdirty; e_phit = 1; e_pdata = m_buf; np = 3; prb_req = "R4";
      end else if (m_phase == 1) begin
        e_pntsl = 1; np = 3; prb_req = "R4";
      end else if (m_phase == 2) begin
        e_pntsl = 1; np = 3; prb_req = "R5";
      end else begin
        e_pntsl = !pk[1]; prb_req = "R7";
      end
    end
    if (rv && e_rdy) begin
      e_vv = 1; e_vd = st[1]; e_va = a; e_vdat = d;
      m_buf = d; m_bdirty = st[1]; np = st[1] ? 1 : 2;
    end
    if (ack && m_phase != 0) np = 0;
    m_phase = np;
    #1;
    cmp_regs();
  endtask

  task automatic idle_cyc();
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #100000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    cmp_regs(); // reset state
    @(negedge clk);
    rst_n = 1;
    // R1: M replacement, downgrade keeps phase, inv-data cancels
    cyc(1, 0, 2'b11, 16'h1234, 32'hDEAD_BEEF, 0, 0, 0, 0);
    cyc(1, 0, 2'b01, 16'h9999, 32'h1111_1111, 0, 0, 0, 0); // R8 blocked while busy
    cyc(0, 0, 0, 0, 0, 1, 2'b10, 0, 1);                    // R6, R9 low outside cancel
    cyc(0, 0, 0, 0, 0, 1, 2'b01, 0, 0);                    // R4
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1);                        // R9
    cyc(0, 0, 0, 0, 0, 1, 2'b00, 0, 0);                    // R7
    cyc(0, 0, 0, 0, 0, 1, 2'b11, 0, 0);                    // R7 miss
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0);                        // R3
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0);                        // R3 ack in idle
    // R2: E replacement together with idle probe
    cyc(1, 0, 2'b01, 16'h0042, 32'hCAFE_0001, 1, 2'b10, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 2'b11, 0, 0);                    // R6 clean data
    cyc(0, 0, 0, 0, 0, 1, 2'b00, 0, 0);                    // R5
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 1);                        // R3 from cancel, R9
    // O replacement, plain inv in dirty wait
    cyc(1, 0, 2'b10, 16'h7777, 32'h0BAD_F00D, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 2'b00, 0, 0);                    // R4 no data
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0);
    // S replacement deferred then accepted
    cyc(1, 1, 2'b00, 16'h0005, 32'h5555_AAAA, 0, 0, 0, 0); // R8
    cyc(1, 0, 2'b00, 16'h0005, 32'h5555_AAAA, 0, 0, 0, 0); // R2
    cyc(0, 0, 0, 0, 0, 1, 2'b01, 1, 0);                    // R3 ack wins over probe
    cyc(1, 0, 2'b11, 16'hFFFF, 32'hFFFF_0000, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 2'b01, 1, 0);                    // R4 reply, R3 ack
    idle_cyc();
    idle_cyc();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule